// File: doc/BRIEF.md
# Byte-Lane Parity Generator and Checker

This block guards a 64-bit data path that is split into eight byte lanes. When the bus owner writes, the block computes one even-parity bit for each lane and presents all eight bits as a registered output. When it reads, the block compares every enabled lane against the parity bit that came with the data. It records which lanes failed and raises an active-low error pulse.

Lane k covers data bits 8k+7 down to 8k. Lane 0 is the least significant byte and lane 7 the most significant. Checking is gated per lane by active-low byte enables, so a byte that was not transferred can never report a failure. A separate active-low check enable decides whether a failure drives the error output. The strobes are single-cycle control pins: data is taken in the cycle its strobe is high, and there is no back-pressure.

Top module: `lane_parity_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, err_n is 1, lane_err is all zeros and par_out is all zeros.
- R2: One clock after a cycle with wr_stb high, par_out[k] equals the XOR of bus_data[8k+7:8k]. Each lane's eight data bits plus par_out[k] therefore hold an even number of ones.
- R3: The parity registered on a write covers all eight lanes, whatever value lane_en_n has.
- R4: In a cycle where wr_stb is low, par_out keeps its value at the next clock edge, even if bus_data changes.
- R5: One clock after a cycle with rd_stb high, lane_err[k] is 1 exactly when lane_en_n[k] is 0 (enabled) and the nine bits bus_data[8k+7:8k] plus par_in[k] hold an odd number of ones.
- R6: A lane whose lane_en_n bit is 1 during a read never sets its lane_err bit, whatever its data and parity are.
- R7: err_n is 0 for exactly one clock: the clock after a read in which chk_en_n is 0 and at least one lane_err bit is set. At every other time err_n is 1.
- R8: With chk_en_n at 1 during a read, lane_err is still updated as in R5, but err_n stays 1.
- R9: In a cycle where rd_stb is low, lane_err keeps its value at the next clock edge.
- R10: When rd_stb and wr_stb are high in the same cycle, the read check and the parity generation both take effect from the same bus_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | 64 | Data word, lane k in bits 8k+7:8k |
| lane_en_n | input | 8 | Active-low byte enables, bit k for lane k |
| par_in | input | 8 | Incoming parity on reads, bit k for lane k |
| chk_en_n | input | 1 | Active-low enable for driving err_n |
| rd_stb | input | 1 | Read strobe: check this cycle's data |
| wr_stb | input | 1 | Write strobe: generate parity for this cycle's data |
| par_out | output | 8 | Registered even parity per lane |
| err_n | output | 1 | Active-low one-cycle parity error pulse |
| lane_err | output | 8 | Per-lane failure mask from the last read |

## Verification
The bench sweeps all 256 byte-enable combinations on reads. Each combination gets its own corruption pattern and check-enable setting, so a design that ignored an enable or swapped lane order would flag lanes the expected mask leaves clear. A sticky err_n, or one that ignores chk_en_n, shows up in the cycle after each read, which must return err_n to 1. A parity sense that is inverted or shifted by one lane breaks the write sweep, which varies every byte value per lane. Idle cycles that change bus_data catch registers that update without their strobe.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;
  parameter int unsigned LANE_COUNT = 8;
  parameter int unsigned LANE_BITS  = 8;
endpackage

// File: rtl/lane_parity_slice.sv
module lane_parity_slice #(
  parameter int unsigned W = lane_parity_pkg::LANE_BITS
) (
  input  logic [W-1:0] lane_data,
  input  logic         lane_par,
  output logic         gen_bit,
  output logic         mismatch
);
  // Even parity: the generated bit makes the count of ones even.
  always_comb begin
    gen_bit  = ^lane_data;
    mismatch = gen_bit ^ lane_par;
  end
endmodule

// File: rtl/lane_error_collect.sv
module lane_error_collect #(
  parameter int unsigned N = lane_parity_pkg::LANE_COUNT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_stb,
  input  logic         wr_stb,
  input  logic         chk_en_n,
  input  logic [N-1:0] lane_en_n,
  input  logic [N-1:0] mismatch,
  input  logic [N-1:0] gen_bits,
  output logic [N-1:0] par_out,
  output logic [N-1:0] lane_err,
  output logic         err_n
);
  logic [N-1:0] hit;

  always_comb hit = mismatch & ~lane_en_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_out  <= '0;
      lane_err <= '0;
      err_n    <= 1'b1;
    end else begin
      if (wr_stb) par_out <= gen_bits;
      if (rd_stb) lane_err <= hit;
      err_n <= !(rd_stb && !chk_en_n && (|hit));
    end
  end

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_n |-> ($past(rd_stb) && !$past(chk_en_n) && (lane_err != '0)));
  // R8
  chk_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chk_en_n) |-> err_n);
  // R6
  masked_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_stb) |-> ((lane_err & $past(lane_en_n)) == '0));
  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_stb) |-> $stable(lane_err));
  // R4
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stb) |-> $stable(par_out));
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit #(
  parameter int unsigned LANES  = lane_parity_pkg::LANE_COUNT,
  parameter int unsigned LANE_W = lane_parity_pkg::LANE_BITS,
  localparam int unsigned BUS_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_data,
  input  logic [LANES-1:0] lane_en_n,
  input  logic [LANES-1:0] par_in,
  input  logic             chk_en_n,
  input  logic             rd_stb,
  input  logic             wr_stb,
  output logic [LANES-1:0] par_out,
  output logic             err_n,
  output logic [LANES-1:0] lane_err
);
  logic [LANES-1:0] gen_bits;
  logic [LANES-1:0] mismatch;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_parity_slice #(.W(LANE_W)) slice_i (
      .lane_data (bus_data[g*LANE_W +: LANE_W]),
      .lane_par  (par_in[g]),
      .gen_bit   (gen_bits[g]),
      .mismatch  (mismatch[g])
    );

    // R2
    even_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_stb) |-> ((^{$past(bus_data[g*LANE_W +: LANE_W]), par_out[g]}) == 1'b0));
  end

  lane_error_collect #(.N(LANES)) collect_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .chk_en_n  (chk_en_n),
    .lane_en_n (lane_en_n),
    .mismatch  (mismatch),
    .gen_bits  (gen_bits),
    .par_out   (par_out),
    .lane_err  (lane_err),
    .err_n     (err_n)
  );
endmodule

// File: tb/lane_parity_unit_tb_top.sv
`timescale 1ns/1ps
module lane_parity_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] bus_data;
  logic [7:0]  lane_en_n;
  logic [7:0]  par_in;
  logic        chk_en_n;
  logic        rd_stb;
  logic        wr_stb;
  logic [7:0]  par_out;
  logic        err_n;
  logic [7:0]  lane_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_parity_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .lane_en_n(lane_en_n),
    .par_in(par_in), .chk_en_n(chk_en_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .par_out(par_out), .err_n(err_n), .lane_err(lane_err)
  );

  function automatic logic [7:0] even_par(input logic [63:0] d);
    logic [7:0] p;
    for (int k = 0; k < 8; k++) begin
      p[k] = 1'b0;
      for (int b = 0; b < 8; b++) p[k] = p[k] ^ d[8*k + b];
    end
    return p;
  endfunction

  function automatic logic [63:0] mk_data(input int n);
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[8*k +: 8] = 8'(n + k*31 + (n >> 3) * k);
    return d;
  endfunction

  task automatic check8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      report();
    end
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  en, cor, expm, prev_par;
    logic        chk, exp_err;
    rst_n = 1'b0; bus_data = '1; lane_en_n = '0; par_in = '1;
    chk_en_n = 1'b0; rd_stb = 1'b1; wr_stb = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state while held in reset
    check8("R1", "err_n", {7'd0, err_n}, 8'd1);
    check8("R1", "lane_err", lane_err, 8'h00);
    check8("R1", "par_out", par_out, 8'h00);
    rd_stb = 1'b0; wr_stb = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    check8("R1", "err_n after release", {7'd0, err_n}, 8'd1);
    check8("R1", "lane_err after release", lane_err, 8'h00);

    // R2, R3, R4: write sweep with varying enables
    for (int n = 0; n < 512; n++) begin
      d = mk_data(n);
      bus_data = d; lane_en_n = 8'(n * 7); wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      check8("R2/R3", "par_out", par_out, even_par(d));
      prev_par = par_out;
      bus_data = ~d ^ 64'h0123_4567_89AB_CDEF;
      @(negedge clk);
      check8("R4", "par_out idle", par_out, prev_par);
    end

    // R5, R6, R7, R8, R9: read sweep over all enable patterns
    for (int n = 0; n < 256; n++) begin
      d   = mk_data(n * 3 + 1);
      en  = 8'(n);
      cor = (n % 4 == 0) ? 8'h00 : (8'(n * 37) ^ 8'h5A);
      chk = n[0] ^ n[3];
      expm = ~en & cor;
      exp_err = !chk && (expm != 8'h00);
      bus_data = d; lane_en_n = en; par_in = even_par(d) ^ cor;
      chk_en_n = chk; rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      check8("R5/R6", "lane_err", lane_err, expm);
      check8(chk ? "R8" : "R7", "err_n", {7'd0, err_n}, {7'd0, !exp_err});
      bus_data = ~d; par_in = ~par_in; lane_en_n = 8'h00; chk_en_n = 1'b0;
      @(negedge clk);
      check8("R9", "lane_err idle", lane_err, expm);
      check8("R7", "err_n one cycle", {7'd0, err_n}, 8'd1);
    end

    // R10: read and write in the same cycle
    d = 64'hFFFF_0000_0F0F_1357;
    bus_data = d; lane_en_n = 8'h00; par_in = even_par(d) ^ 8'h81;
    chk_en_n = 1'b0; rd_stb = 1'b1; wr_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0;
    check8("R10", "par_out", par_out, even_par(d));
    check8("R10", "lane_err", lane_err, 8'h81);
    check8("R10", "err_n", {7'd0, err_n}, 8'd0);

    // R1: reset clears state set above
    rst_n = 1'b0;
    @(negedge clk);
    check8("R1", "lane_err cleared", lane_err, 8'h00);
    check8("R1", "par_out cleared", par_out, 8'h00);
    done = 1'b1;
    report();
  end
endmodule